// File: doc/BRIEF.md
# Cyclic Code Encoder and Framer

This block turns a serial stream of information bits into framed codewords of a (21,11) systematic cyclic code. Every frame is 42 cycles long and holds three sections: a fixed 21-bit synchronisation pattern, then 11 information bits copied straight from the input, then 10 check bits. The check bits are the remainder of the information polynomial, multiplied by x^10, divided by the generator x^10 + x^7 + x^6 + x^4 + x^2 + 1. The remainder is formed bit by bit in a division shift register while the information bits pass through.

The source presents one information bit per cycle on `infoBit`. The block samples it only in the 11 information slots, highest index first. A one-cycle `startPulse` marks the first information slot of each frame and also clears the remainder register. Frames follow one another without gaps from the first cycle after reset. A second output, `refOut`, carries the same error-free stream so that a downstream test harness can compare it against a copy it has corrupted on purpose.

Top module: `ccEncTop`

## Requirements
- R1: In the first cycle after `rst` (synchronous, active high) is released, the frame position is 0: `serOut` carries the first sync bit (0) and `startPulse` is low.
- R2: In frame positions 0 to 20, `serOut` carries the sync pattern 001101011110111000000, leftmost bit first.
- R3: In frame positions 21 to 31, `serOut` equals `infoBit` in the same cycle. The bit taken at position 21 is u10 and the bit taken at position 31 is u0.
- R4: In frame positions 32 to 41, `serOut` carries check bits r9 down to r0. Here r9..r0 are the coefficients of (u10..u0 as a polynomial with u_i at x^i) * x^10 mod (x^10 + x^7 + x^6 + x^4 + x^2 + 1).
- R5: `startPulse` is high in frame position 21 only, so it recurs every 42 cycles.
- R6: `infoBit` outside positions 21 to 31 has no effect on `serOut`. The check bits of a frame depend only on that frame's information bits.
- R7: An information word with only u0 set yields check bits r9..r0 = 0011010101.
- R8: An information word with all 11 bits set yields check bits r9..r0 = 0001001100.
- R9: `refOut` equals `serOut` in every cycle.
- R10: Frames repeat back to back with no idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| infoBit | input | 1 | Information bit offered in the current cycle |
| serOut | output | 1 | Framed serial output |
| startPulse | output | 1 | High in the first information slot of each frame |
| refOut | output | 1 | Error-free copy of the serial output |

## Verification
The sync bits and the passed-through information bits are due in the same cycle as their frame position. The bench drives `infoBit` shortly after each rising edge and samples one nanosecond later, within that same cycle. Each check bit depends on information bits that were registered on earlier edges. The bench therefore predicts the whole 10-bit remainder from the frame's word and compares one bit per cycle in positions 32 to 41. `startPulse` is checked in every cycle against the bench's own position count. Random bits driven outside the information window check that those bits leave the output unchanged.

// File: rtl/ccEncPkg.sv
package ccEncPkg;
  localparam int SYNC_LEN  = 21;
  localparam int INFO_LEN  = 11;
  localparam int PAR_LEN   = 10;
  localparam int FRAME_LEN = SYNC_LEN + INFO_LEN + PAR_LEN;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  localparam logic [SYNC_LEN-1:0] SYNC_WORD = 21'b001101011110111000000;
  localparam logic [PAR_LEN:0]    GEN_POLY  = 11'b10011010101;

  typedef struct packed {
    logic             inSync;
    logic             inInfo;
    logic             inParity;
    logic             clearRem;
    logic [CNT_W-1:0] syncIdx;
  } encStrobe_t;
endpackage

// File: rtl/ccEncCtrl.sv
module ccEncCtrl
  import ccEncPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output encStrobe_t strobe
);
  localparam logic [CNT_W-1:0] LAST_POS   = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] INFO_FIRST = CNT_W'(SYNC_LEN);
  localparam logic [CNT_W-1:0] PAR_FIRST  = CNT_W'(SYNC_LEN + INFO_LEN);
  localparam logic [CNT_W-1:0] SYNC_TOP   = CNT_W'(SYNC_LEN - 1);

  logic [CNT_W-1:0] framePos;

  always_ff @(posedge clk) begin
    if (rst)                    framePos <= '0;
    else if (framePos == LAST_POS) framePos <= '0;
    else                        framePos <= framePos + 1'b1;
  end

  always_comb begin
    strobe.inSync   = (framePos < INFO_FIRST);
    strobe.inInfo   = (framePos >= INFO_FIRST) && (framePos < PAR_FIRST);
    strobe.inParity = (framePos >= PAR_FIRST);
    strobe.clearRem = (framePos == INFO_FIRST);
    strobe.syncIdx  = SYNC_TOP - framePos;
  end
endmodule

// File: rtl/ccEncDatapath.sv
module ccEncDatapath
  import ccEncPkg::*;
#(
  parameter int                 REM_W = PAR_LEN,
  parameter logic [REM_W:0]     POLY  = GEN_POLY
)(
  input  logic       clk,
  input  logic       rst,
  input  encStrobe_t strobe,
  input  logic       infoBit,
  output logic       serOut
);
  logic [REM_W-1:0] remReg;
  logic [REM_W-1:0] remBase;
  logic [REM_W-1:0] divNext;
  logic             feedBit;

  always_comb begin
    remBase = strobe.clearRem ? '0 : remReg;
    feedBit = infoBit ^ remBase[REM_W-1];
    divNext = {remBase[REM_W-2:0], 1'b0} ^ ({REM_W{feedBit}} & POLY[REM_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst)                  remReg <= '0;
    else if (strobe.inInfo)   remReg <= divNext;
    else if (strobe.inParity) remReg <= {remReg[REM_W-2:0], 1'b0};
  end

  always_comb begin
    if (strobe.inSync)      serOut = SYNC_WORD[strobe.syncIdx];
    else if (strobe.inInfo) serOut = infoBit;
    else                    serOut = remReg[REM_W-1];
  end
endmodule

// File: rtl/ccEncTop.sv
module ccEncTop
  import ccEncPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic infoBit,
  output logic serOut,
  output logic startPulse,
  output logic refOut
);
  encStrobe_t strobe;
  logic       lineBit;

  ccEncCtrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  ccEncDatapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .infoBit (infoBit),
    .serOut  (lineBit)
  );

  assign serOut     = lineBit;
  assign refOut     = lineBit;
  assign startPulse = strobe.clearRem;
endmodule

// File: rtl/ccEncChecker.sv
module ccEncChecker
  import ccEncPkg::*;
(
  input logic clk,
  input logic rst,
  input logic infoBit,
  input logic serOut,
  input logic startPulse,
  input logic refOut
);
  logic [CNT_W-1:0] ckPos;

  always_ff @(posedge clk) begin
    if (rst)                                   ckPos <= '0;
    else if (ckPos == CNT_W'(FRAME_LEN - 1))   ckPos <= '0;
    else                                       ckPos <= ckPos + 1'b1;
  end

  p_reset_pos_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!startPulse && serOut == SYNC_WORD[SYNC_LEN-1]));

  p_sync_word_r2: assert property (@(posedge clk) disable iff (rst)
    (ckPos < CNT_W'(SYNC_LEN)) |-> (serOut == SYNC_WORD[CNT_W'(SYNC_LEN - 1) - ckPos]));

  p_info_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (ckPos >= CNT_W'(SYNC_LEN) && ckPos < CNT_W'(SYNC_LEN + INFO_LEN)) |-> (serOut == infoBit));

  p_start_slot_r5: assert property (@(posedge clk) disable iff (rst)
    startPulse == (ckPos == CNT_W'(SYNC_LEN)));

  p_ref_copy_r9: assert property (@(posedge clk) disable iff (rst)
    refOut == serOut);
endmodule

bind ccEncTop ccEncChecker u_chk (
  .clk        (clk),
  .rst        (rst),
  .infoBit    (infoBit),
  .serOut     (serOut),
  .startPulse (startPulse),
  .refOut     (refOut)
);

// File: tb/sim_ccEncTop.sv
`timescale 1ns/1ps
module sim_ccEncTop;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic infoBit = 1'b0;
  logic serOut, startPulse, refOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  localparam logic [20:0] SYNC_EXP = 21'b001101011110111000000;
  localparam int NUM_FRAMES = 40;

  always #2 clk = ~clk;

  ccEncTop u0 (
    .clk(clk), .rst(rst), .infoBit(infoBit),
    .serOut(serOut), .startPulse(startPulse), .refOut(refOut)
  );

  function automatic logic [9:0] remOf(input logic [10:0] w);
    logic [20:0] d;
    d = {w, 10'b0};
    for (int i = 20; i >= 10; i--)
      if (d[i]) d = d ^ (21'(11'b10011010101) << (i - 10));
    return d[9:0];
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    int unsigned seed;
    logic [10:0] word;
    logic [9:0]  par;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int f = 0; f < NUM_FRAMES; f++) begin
      if (f == 0)      begin word = 11'b00000000001; par = 10'b0011010101; end
      else if (f == 1) begin word = 11'b11111111111; par = 10'b0001001100; end
      else if (f == 2) begin word = 11'b00000000000; par = remOf(word); end
      else if (f == 3) begin word = 11'b10000000000; par = remOf(word); end
      else begin word = 11'($urandom); par = remOf(word); end
      for (int p = 0; p < 42; p++) begin
        if (p >= 21 && p <= 31) infoBit = word[31 - p];
        else                    infoBit = 1'($urandom);
        #1;
        if (f == 0 && p == 0) begin
          check("R1 first sync bit", serOut, 1'b0);
          check("R1 start low", startPulse, 1'b0);
        end
        if (p < 21)       check("R2 sync bit", serOut, SYNC_EXP[20 - p]);
        else if (p <= 31) check("R3 info pass", serOut, word[31 - p]);
        else if (f == 0)  check("R7 u0-only parity", serOut, par[41 - p]);
        else if (f == 1)  check("R8 all-ones parity", serOut, par[41 - p]);
        else              check("R4 R6 parity", serOut, par[41 - p]);
        check("R5 R10 start slot", startPulse, (p == 21));
        check("R9 ref copy", refOut, serOut);
        @(posedge clk);
        #1;
      end
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule